// File: doc/BRIEF.md
# H-Bridge Direction and PWM Gate Controller

This block is the digital heart of a full-bridge DC motor driver. Two direction inputs pick one of four operating modes. The block turns that mode into four gate commands: the high-side and low-side switch of leg A, and the same pair for leg B. Only the low-side switches follow the PWM input. A PWM low level forces them off, and a minimum off time stops short PWM glitches from chopping them. The high-side switches never see PWM.

Each leg has its own enable input, driven by an external fault supervisor. Pulling it low floats that half-bridge. A change of direction inputs takes effect only after a configurable hold-off window. Each leg that swaps from one switch to the other passes through a dead time with both switches off. A sense-enable flag tells the current-measurement path when a direction mode, not a brake mode, is active. All inputs are asynchronous and pass through a two-flop synchronizer. Every timer counts system clock cycles derived from a clock-frequency parameter.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: Mode decode from the committed direction pair (dir_a, dir_b). (1,1) turns on both high sides. (1,0) turns on leg A's high side and leg B's low side (clockwise). (0,1) turns on leg A's low side and leg B's high side (counter-clockwise). (0,0) turns on both low sides.
- R2: When the synchronized PWM input is low, both low-side commands turn off 4 clock cycles after the input changes. High-side commands are unaffected. When PWM returns high, the low side selected by the mode turns back on, also 4 cycles after the input rises.
- R3: Once PWM low has been recognised, the low sides stay off for at least MIN_OFF cycles. MIN_OFF is MIN_OFF_NS converted to cycles and rounded up. This holds even if PWM returns high sooner. After reset the same off window applies before any low side turns on.
- R4: A new direction pair is committed only after it has been seen unchanged for HOLD cycles. HOLD is MODE_DELAY_US converted to cycles and rounded up. The gate outputs change HOLD+3 cycles after the input change.
- R5: A pending request that changes before it is committed restarts the hold count. A return to the committed mode cancels the pending request.
- R6: sense_en_o is 1 only while the committed mode is clockwise or counter-clockwise. It is 0 in both brake modes. It ignores PWM and the leg enables.
- R7: A low leg enable turns off both switches of that leg 3 cycles after the input change. When the enable returns high and the leg's target is the switch it last used, that switch turns on again 3 cycles after the input change, with no dead time.
- R8: A leg never has its high and low commands on at once. A leg that changes from one switch to the other holds both off for exactly DEAD_CYC cycles.
- R9: During reset, and until the synchronizer is filled and a mode is committed, all four gate commands and sense_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a_i | input | 1 | Direction input A (asynchronous) |
| dir_b_i | input | 1 | Direction input B (asynchronous) |
| pwm_i | input | 1 | Speed PWM input (asynchronous) |
| leg_a_en_i | input | 1 | Leg A enable, low floats leg A |
| leg_b_en_i | input | 1 | Leg B enable, low floats leg B |
| hs_a_o | output | 1 | Leg A high-side gate command |
| ls_a_o | output | 1 | Leg A low-side gate command |
| hs_b_o | output | 1 | Leg B high-side gate command |
| ls_b_o | output | 1 | Leg B low-side gate command |
| sense_en_o | output | 1 | Current-sense enable |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz, MODE_DELAY_US at 300, MIN_OFF_NS at 6000 and DEAD_CYC at 3. These values give a 300-cycle hold, a 6-cycle minimum PWM off time and a 3-cycle dead time. At those sizes the bench can walk every mode transition, including a cancelled request and a restarted one, in a few thousand cycles. It can also check each boundary at its exact cycle: the last cycle before a commit, the last cycle of a dead time and the end of a stretched PWM pulse. A one-cycle PWM glitch falls well inside the minimum off window, so the stretch it must receive shows up clearly at the ports.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Operating mode, encoded as {dir_a, dir_b}
    typedef enum logic [1:0] {
        MODE_BRAKE_GND = 2'b00,
        MODE_CCW       = 2'b01,
        MODE_CW        = 2'b10,
        MODE_BRAKE_SUP = 2'b11
    } drive_mode_t;

    // Switch selection for one half-bridge
    typedef enum logic [1:0] {
        SW_NONE = 2'b00,
        SW_HIGH = 2'b01,
        SW_LOW  = 2'b10
    } leg_sel_t;

    // Desired switch of one leg: leg A follows dir_a, leg B follows dir_b.
    function automatic leg_sel_t leg_target(drive_mode_t m, logic is_leg_b, logic pwm_ok);
        logic want_high;
        want_high = is_leg_b ? m[0] : m[1];
        if (want_high)   return SW_HIGH;
        else if (pwm_ok) return SW_LOW;
        else             return SW_NONE;
    endfunction

    function automatic logic is_drive_mode(drive_mode_t m);
        return m[1] ^ m[0];
    endfunction

    // Ceiling of hz * amount / per, never below one cycle
    function automatic int cycles_for(longint hz, longint amount, longint per);
        longint c;
        c = (hz * amount + per - 1) / per;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [1:0]       fill;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
        if (sync_q.fill != 2'd2) sync_d.fill = sync_q.fill + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o  = sync_q.stage2;
    assign valid_o = (sync_q.fill == 2'd2);

endmodule

// File: rtl/hbg_pwm_gate.sv
module hbg_pwm_gate #(
    parameter int MIN_OFF_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_i,
    input  logic valid_i,
    output logic pwm_ok_o
);
    localparam int HW = $clog2(MIN_OFF_CYC + 1);

    typedef struct packed {
        logic          ok;
        logic [HW-1:0] hold;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (gate_q.ok) begin
            if (!(pwm_i && valid_i)) begin
                gate_d.ok   = 1'b0;
                gate_d.hold = HW'(MIN_OFF_CYC - 1);
            end
        end else if (gate_q.hold != '0) begin
            gate_d.hold = gate_q.hold - HW'(1);
        end else begin
            gate_d.ok = pwm_i && valid_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q.ok   <= 1'b0;
            gate_q.hold <= HW'(MIN_OFF_CYC - 1);
        end else begin
            gate_q <= gate_d;
        end
    end

    assign pwm_ok_o = gate_q.ok;

    // Independent measure of the low run of the gated PWM
    logic [HW-1:0] chk_low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  chk_low_run <= '0;
        else if (gate_q.ok)                          chk_low_run <= '0;
        else if (chk_low_run != HW'(MIN_OFF_CYC))    chk_low_run <= chk_low_run + HW'(1);
    end

    assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q.ok) |-> (chk_low_run >= HW'(MIN_OFF_CYC)));

    assert_low_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_i && valid_i) |=> !gate_q.ok);

endmodule

// File: rtl/hbg_mode_hold.sv
module hbg_mode_hold
    import hbg_pkg::*;
#(
    parameter int HOLD_CYC = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dir_a_i,
    input  logic        dir_b_i,
    input  logic        valid_i,
    output drive_mode_t mode_o,
    output logic        mode_vld_o
);
    localparam int RW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        drive_mode_t   mode;
        drive_mode_t   pend;
        logic          vld;
        logic [RW-1:0] run;
    } hold_t;

    hold_t hold_d, hold_q;
    drive_mode_t req;
    logic [RW-1:0] run_next;

    always_comb begin
        req      = drive_mode_t'({dir_a_i, dir_b_i});
        hold_d   = hold_q;
        run_next = (req == hold_q.pend) ? hold_q.run + RW'(1) : RW'(1);
        if (!hold_q.vld) begin
            if (valid_i) begin
                hold_d.mode = req;
                hold_d.pend = req;
                hold_d.vld  = 1'b1;
                hold_d.run  = '0;
            end
        end else if (req == hold_q.mode) begin
            hold_d.pend = req;
            hold_d.run  = '0;
        end else if (run_next >= RW'(HOLD_CYC)) begin
            hold_d.mode = req;
            hold_d.pend = req;
            hold_d.run  = '0;
        end else begin
            hold_d.pend = req;
            hold_d.run  = run_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.mode <= MODE_BRAKE_GND;
            hold_q.pend <= MODE_BRAKE_GND;
            hold_q.vld  <= 1'b0;
            hold_q.run  <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign mode_o     = hold_q.mode;
    assign mode_vld_o = hold_q.vld;

    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.vld && req == hold_q.mode) |=> (hold_q.mode == $past(hold_q.mode)));

    generate
        if (HOLD_CYC >= 3) begin : g_hold_chk
            assert_commit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_q.vld && $past(hold_q.vld) && hold_q.mode != $past(hold_q.mode))
                |-> ($past(req) == hold_q.mode && $past(req, 2) == hold_q.mode));
        end
    endgenerate

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 25
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_sel_t want_i,
    input  logic     en_i,
    output logic     hs_o,
    output logic     ls_o
);
    localparam int GW      = $clog2(DEAD_CYC + 1);
    localparam int GAP_MAX = DEAD_CYC - 1;

    typedef struct packed {
        logic          hs;
        logic          ls;
        leg_sel_t      last;
        logic [GW-1:0] gap;
    } leg_t;

    leg_t leg_d, leg_q;
    leg_sel_t tgt, cur;

    always_comb begin
        leg_d = leg_q;
        tgt   = en_i ? want_i : SW_NONE;
        cur   = leg_q.hs ? SW_HIGH : (leg_q.ls ? SW_LOW : SW_NONE);
        if (cur != SW_NONE) begin
            if (tgt != cur) begin
                leg_d.hs  = 1'b0;
                leg_d.ls  = 1'b0;
                leg_d.gap = '0;
            end
        end else if (tgt != SW_NONE &&
                     (tgt == leg_q.last || leg_q.last == SW_NONE || leg_q.gap >= GW'(GAP_MAX))) begin
            leg_d.hs   = (tgt == SW_HIGH);
            leg_d.ls   = (tgt == SW_LOW);
            leg_d.last = tgt;
        end else if (leg_q.gap < GW'(GAP_MAX)) begin
            leg_d.gap = leg_q.gap + GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leg_q.hs   <= 1'b0;
            leg_q.ls   <= 1'b0;
            leg_q.last <= SW_NONE;
            leg_q.gap  <= '0;
        end else begin
            leg_q <= leg_d;
        end
    end

    assign hs_o = leg_q.hs;
    assign ls_o = leg_q.ls;

    // Independent tracking of the off run and of the side last driven
    logic [GW-1:0] chk_off;
    leg_sel_t      chk_side;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_off  <= '0;
            chk_side <= SW_NONE;
        end else begin
            if (leg_q.hs || leg_q.ls)             chk_off <= '0;
            else if (chk_off != GW'(DEAD_CYC))    chk_off <= chk_off + GW'(1);
            if (leg_q.hs)      chk_side <= SW_HIGH;
            else if (leg_q.ls) chk_side <= SW_LOW;
        end
    end

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_q.hs && leg_q.ls));

    assert_dead_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(leg_q.hs) && chk_side == SW_LOW) |-> (chk_off >= GW'(DEAD_CYC)));

    assert_dead_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(leg_q.ls) && chk_side == SW_HIGH) |-> (chk_off >= GW'(DEAD_CYC)));

    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!leg_q.hs && !leg_q.ls));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int MODE_DELAY_US = 600,
    parameter int MIN_OFF_NS    = 6000,
    parameter int DEAD_CYC      = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic pwm_i,
    input  logic leg_a_en_i,
    input  logic leg_b_en_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o,
    output logic sense_en_o
);
    localparam int HOLD_CYC    = cycles_for(longint'(CLK_HZ), longint'(MODE_DELAY_US), 64'd1_000_000);
    localparam int MIN_OFF_CYC = cycles_for(longint'(CLK_HZ), longint'(MIN_OFF_NS), 64'd1_000_000_000);
    localparam int NUM_IN      = 5;
    localparam int NUM_LEGS    = 2;

    logic [NUM_IN-1:0] raw_in, syn_in;
    logic              syn_vld;
    drive_mode_t       mode;
    logic              mode_vld;
    logic              pwm_ok;
    leg_sel_t          leg_want [NUM_LEGS];
    logic [NUM_LEGS-1:0] leg_en, hs_v, ls_v;

    assign raw_in = {dir_a_i, dir_b_i, pwm_i, leg_a_en_i, leg_b_en_i};

    hbg_sync #(.WIDTH(NUM_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in),
        .valid_o (syn_vld)
    );

    hbg_mode_hold #(.HOLD_CYC(HOLD_CYC)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_a_i    (syn_in[4]),
        .dir_b_i    (syn_in[3]),
        .valid_i    (syn_vld),
        .mode_o     (mode),
        .mode_vld_o (mode_vld)
    );

    hbg_pwm_gate #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_i    (syn_in[2]),
        .valid_i  (syn_vld),
        .pwm_ok_o (pwm_ok)
    );

    always_comb begin
        for (int i = 0; i < NUM_LEGS; i++) begin
            leg_want[i] = mode_vld ? leg_target(mode, (i == 1), pwm_ok) : SW_NONE;
        end
        leg_en = {syn_in[0], syn_in[1]} & {NUM_LEGS{syn_vld}};
    end

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
                .clk    (clk),
                .rst_n  (rst_n),
                .want_i (leg_want[g]),
                .en_i   (leg_en[g]),
                .hs_o   (hs_v[g]),
                .ls_o   (ls_v[g])
            );
        end
    endgenerate

    typedef struct packed {
        logic sense;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.sense = mode_vld && is_drive_mode(mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hs_a_o     = hs_v[0];
    assign ls_a_o     = ls_v[0];
    assign hs_b_o     = hs_v[1];
    assign ls_b_o     = ls_v[1];
    assign sense_en_o = ctl_q.sense;

    assert_sense_not_brake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en_o |-> !(hs_a_o && hs_b_o));

    assert_off_until_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_vld |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o || sense_en_o));

endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_bench;

    localparam int H = 300;   // hold cycles at CLK_HZ=1 MHz, 300 us
    localparam int M = 6;     // min off cycles, 6000 ns
    localparam int D = 3;     // dead cycles

    // expected output vector: {sense, hs_a, ls_a, hs_b, ls_b}
    localparam logic [4:0] V_OFF  = 5'b00000;
    localparam logic [4:0] V_CW   = 5'b11001;
    localparam logic [4:0] V_CCW  = 5'b10110;
    localparam logic [4:0] V_BGND = 5'b00101;
    localparam logic [4:0] V_BSUP = 5'b01010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 1'b1, dir_b = 1'b0, pwm = 1'b1, en_a = 1'b1, en_b = 1'b1;
    logic hs_a, ls_a, hs_b, ls_b, sense_en;

    int unsigned cyc = 0;
    int total = 0;
    int bad = 0;
    int overlaps = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        logic [4:0]  val;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hbridge_gate_ctrl #(
        .CLK_HZ(1_000_000), .MODE_DELAY_US(300), .MIN_OFF_NS(6000), .DEAD_CYC(D)
    ) u_hbridge_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b), .pwm_i(pwm),
        .leg_a_en_i(en_a), .leg_b_en_i(en_b),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b), .sense_en_o(sense_en)
    );

    // Monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        logic [4:0] obs;
        exp_t e;
        obs = {sense_en, hs_a, ls_a, hs_b, ls_b};
        if ((hs_a && ls_a) || (hs_b && ls_b)) overlaps++;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            e = sbq.pop_front();
            total++;
            if (e.at != cyc || obs !== e.val) begin
                bad++;
                $display("FAIL %s cycle=%0d got=%b exp=%b (due %0d)", e.req, cyc, obs, e.val, e.at);
            end
        end
    end

    task automatic expect_at(input int unsigned at, input logic [4:0] v, input string r);
        exp_t e;
        e.at = at; e.val = v; e.req = r;
        sbq.push_back(e);
    endtask

    task automatic apply(input logic a, input logic b, input logic p, input logic ea,
                         input logic eb, output int unsigned t);
        @(negedge clk);
        dir_a = a; dir_b = b; pwm = p; en_a = ea; en_b = eb;
        t = cyc;
    endtask

    task automatic wait_until(input int unsigned at);
        while (cyc < at) @(negedge clk);
    endtask

    initial begin
        int unsigned t, t2;
        // R9: reset holds everything off
        repeat (3) @(negedge clk);
        expect_at(cyc + 2, V_OFF, "R9 in reset");
        wait_until(cyc + 4);
        rst_n = 1'b1;
        t = cyc;
        expect_at(t + 3, V_OFF,   "R9 before commit");
        expect_at(t + 4, 5'b11000, "R9 commit, R3 low side held");
        expect_at(t + 6, 5'b11000, "R3 reset off window");
        expect_at(t + 7, V_CW,    "R1 clockwise");
        wait_until(t + 20);

        // R2: PWM low removes low side only
        apply(1, 0, 0, 1, 1, t);
        expect_at(t + 3, V_CW,     "R2 latency");
        expect_at(t + 4, 5'b11000, "R2 pwm low");
        wait_until(t + 20);
        apply(1, 0, 1, 1, 1, t2);
        expect_at(t2 + 3, 5'b11000, "R2 latency rise");
        expect_at(t2 + 4, V_CW,     "R2 pwm high");
        wait_until(t2 + 20);

        // R3: one-cycle glitch stretched to minimum off
        apply(1, 0, 0, 1, 1, t);
        apply(1, 0, 1, 1, 1, t2);
        expect_at(t + 4, 5'b11000, "R3 glitch off");
        expect_at(t + M + 3, 5'b11000, "R3 still off");
        expect_at(t + M + 4, V_CW, "R3 back on");
        wait_until(t + 30);

        // R4/R8: clockwise to counter-clockwise
        apply(0, 1, 1, 1, 1, t);
        expect_at(t + 150,       V_CW,     "R4 mid hold");
        expect_at(t + H + 2,     V_CW,     "R4 last old cycle");
        expect_at(t + H + 3,     5'b10000, "R8 dead start");
        expect_at(t + H + 2 + D, 5'b10000, "R8 dead end");
        expect_at(t + H + 3 + D, V_CCW,    "R1 counter-clockwise");
        wait_until(t + H + 20);

        // R5: request withdrawn before commit
        apply(1, 1, 1, 1, 1, t);
        wait_until(t + 100);
        apply(0, 1, 1, 1, 1, t2);
        expect_at(t + H + 10,  V_CCW, "R5 cancel");
        expect_at(t2 + H + 10, V_CCW, "R5 cancel stays");
        wait_until(t2 + H + 20);

        // R5: changed request restarts count; R1/R6 brake to ground
        apply(1, 1, 1, 1, 1, t);
        wait_until(t + 100);
        apply(0, 0, 1, 1, 1, t2);
        expect_at(t + H + 3,      V_CCW,    "R5 restart");
        expect_at(t2 + H + 2,     V_CCW,    "R5 restart last old");
        expect_at(t2 + H + 3,     5'b00100, "R6 sense off, R8 dead");
        expect_at(t2 + H + 3 + D, V_BGND,   "R1 brake ground");
        wait_until(t2 + H + 20);

        // R2: PWM low in ground brake floats both legs
        apply(0, 0, 0, 1, 1, t);
        expect_at(t + 4, V_OFF, "R2 brake ground pwm low");
        wait_until(t + 10);
        apply(0, 0, 1, 1, 1, t2);
        expect_at(t2 + 4, V_BGND, "R2 brake ground pwm high");
        wait_until(t2 + 20);

        // R1/R8: ground brake to supply brake
        apply(1, 1, 1, 1, 1, t);
        expect_at(t + H + 3,     V_OFF,  "R8 both legs dead");
        expect_at(t + H + 2 + D, V_OFF,  "R8 dead end");
        expect_at(t + H + 3 + D, V_BSUP, "R1 brake supply");
        wait_until(t + H + 20);

        // R2: PWM has no effect on high sides
        apply(1, 1, 0, 1, 1, t);
        expect_at(t + 4,  V_BSUP, "R2 high side kept");
        expect_at(t + 12, V_BSUP, "R2 high side kept late");
        wait_until(t + 15);
        apply(1, 1, 1, 1, 1, t);
        wait_until(t + 10);

        // R1: supply brake to clockwise
        apply(1, 0, 1, 1, 1, t);
        expect_at(t + H + 3,     5'b11000, "R6 sense on, R8 dead");
        expect_at(t + H + 3 + D, V_CW,     "R1 clockwise again");
        wait_until(t + H + 20);

        // R7: leg enables
        apply(1, 0, 1, 0, 1, t);
        expect_at(t + 2,  V_CW,     "R7 latency");
        expect_at(t + 3,  5'b10001, "R7 leg A floats");
        expect_at(t + 10, 5'b10001, "R7 leg A stays off, R6 sense kept");
        wait_until(t + 12);
        apply(1, 0, 1, 1, 1, t2);
        expect_at(t2 + 3, V_CW, "R7 leg A restored no dead");
        wait_until(t2 + 10);
        apply(1, 0, 1, 1, 0, t);
        expect_at(t + 3, 5'b11000, "R7 leg B floats");
        wait_until(t + 10);
        apply(1, 0, 1, 1, 1, t2);
        expect_at(t2 + 3, V_CW, "R7 leg B restored");
        wait_until(t2 + 10);

        while (sbq.size() > 0) @(negedge clk);
        total++;
        if (overlaps != 0) begin
            bad++;
            $display("FAIL R8 shoot-through cycles got=%0d exp=0", overlaps);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule